// File: doc/BRIEF.md
# SCSI Controller Command and Interrupt Unit

This block is the byte-wide register front end of a simple SCSI bus controller. A host writes a command byte, and the unit decodes it into fixed outcomes: it loads the interrupt-cause, status and sequence-step registers, raises a level interrupt where the command calls for one, and emits one-cycle strobes toward a FIFO and a DMA engine that live outside this block. Reading the interrupt-cause register acknowledges the interrupt. That read clears the cause, drops the terminal-count and pending flags in status, and moves the sequence step to the command-done code.

Selection is modelled abstractly. A vector reports which of the eight target IDs are present. A select command aimed at an absent target ends at once with a disconnect. A select aimed at a present target raises a request, which stays up until the bus side answers with a one-cycle done pulse. Bus phases, arbitration and the data path are outside this block.

The host address is shifted right by a parameter to form a 4-bit register offset. Reads and writes at the same offset may reach different registers.

Top module: `scsi_cmd_irq_unit`

## Requirements
- R1: After reset, status (offset 0x4) reads 0x00, interrupt cause (0x5) reads 0x00, sequence step (0x6) reads 0, configuration (0x8) reads 0x07, chip ID (0xE) reads 0x04, fault (0xB) reads 0x00, and irq is low.
- R2: The register offset is bits [ADDR_SHIFT+3:ADDR_SHIFT] of the address, so address bits below the shift are ignored. The default shift is 2.
- R3: Writing offset 0x4 sets the 3-bit selection target ID and does not change the status value read back at offset 0x4.
- R4: Raising an interrupt sets status bit 7 and drives irq high. irq always follows status bit 7.
- R5: A read of offset 0x5 (with no write in the same cycle) returns the current cause. It then clears the cause, clears status bits 7 and 4, sets the sequence step to 4 and lowers irq.
- R6: Command code 0x01 sets the cause to 0x08, sets the sequence step to 0, pulses fifo_flush for one cycle and raises no interrupt.
- R7: Command code 0x03 sets the cause to 0x80. It raises an interrupt only when configuration bit 6 is clear.
- R8: Command code 0x02 returns every register to its R1 value, clears the stored target ID and cancels any pending selection.
- R9: Code 0x12 sets the cause to 0x20, sets the sequence step to 0 and raises an interrupt. Code 0x44 clears the cause. Code 0x11 sets the cause to 0x08, ORs 0x07 into status and raises an interrupt. Codes 0x1A and 0x00 change no register.
- R10: For select codes 0x42 and 0x43, if the target at the stored ID is absent, status becomes 0, the cause becomes 0x20, the sequence step becomes 0 and an interrupt is raised.
- R11: A select aimed at a present target drives sel_req high, with sel_target set to the ID, until sel_done arrives. The outcome is then status 0x10 (code 0x42) or 0x12 (code 0x43), cause 0x18 and sequence step 4, and an interrupt is raised.
- R12: Any other command code changes no register. It sets bit 0 of the fault register (0xB), which stays set until a reset.
- R13: The command code is write-data bits [6:0]. Bit 7 set on any legal code other than 0x02 produces a one-cycle dma_start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Host byte address |
| bus_rd | input | 1 | Read strobe (side effects at the clock edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq | output | 1 | Level interrupt |
| tgt_present | input | TGT_N | One bit per target ID, set if present |
| sel_req | output | 1 | Selection in progress |
| sel_target | output | TGT_W | ID of the selected target |
| sel_done | input | 1 | Selection finished (one-cycle pulse) |
| fifo_flush | output | 1 | One-cycle FIFO flush strobe |
| dma_start | output | 1 | One-cycle DMA start strobe |

## Verification
The bench aims at the acknowledge read. A design that drops the terminal-count bit in status but keeps the pending flag would leave irq stuck high. One that forgets the sequence rewrite would read back 0 instead of 4. It checks the configuration mask on bus reset, where a wrong polarity would interrupt only when masked. It checks that a reset command in the middle of a selection drops the request, because a design that misses this would later apply a stale outcome on sel_done. It also checks that unknown codes leave every register untouched while the sticky fault bit survives later legal commands, and that the DMA bit neither changes the decoded code nor fires on illegal codes.

// File: rtl/scsi_ciu_pkg.sv
package scsi_ciu_pkg;
  localparam int OFS_W  = 4;
  localparam int BYTE_W = 8;
  localparam int SEQ_W  = 3;

  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // register offsets (read and write banks share the offset space)
  localparam ofs_t OFS_CMD    = 4'h3;
  localparam ofs_t OFS_STAT   = 4'h4;
  localparam ofs_t OFS_TGTID  = 4'h4;
  localparam ofs_t OFS_CAUSE  = 4'h5;
  localparam ofs_t OFS_STEP   = 4'h6;
  localparam ofs_t OFS_CFG    = 4'h8;
  localparam ofs_t OFS_FAULT  = 4'hB;
  localparam ofs_t OFS_CHIPID = 4'hE;

  // command codes (bits 6:0 of the command byte)
  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_CHIPRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_CMPLSEQ = 7'h11;
  localparam logic [6:0] OP_MSGOK   = 7'h12;
  localparam logic [6:0] OP_ATN     = 7'h1A;
  localparam logic [6:0] OP_SEL     = 7'h42;
  localparam logic [6:0] OP_SELSTOP = 7'h43;
  localparam logic [6:0] OP_SELEN   = 7'h44;

  // interrupt cause bits
  localparam byte_t CS_DONE  = 8'h08;
  localparam byte_t CS_SVC   = 8'h10;
  localparam byte_t CS_DISC  = 8'h20;
  localparam byte_t CS_BUSRST = 8'h80;

  // status bits and phase codes
  localparam byte_t ST_PEND  = 8'h80;
  localparam byte_t ST_TCNT  = 8'h10;
  localparam byte_t PH_DOUT  = 8'h00;
  localparam byte_t PH_CMD   = 8'h02;
  localparam byte_t PH_MSGIN = 8'h07;

  localparam logic [SEQ_W-1:0] STEP_ZERO = 3'd0;
  localparam logic [SEQ_W-1:0] STEP_DONE = 3'd4;

  localparam byte_t CFG_INIT   = 8'h07;
  localparam int    CFG_MASKBIT = 6;
  localparam byte_t CHIPID_VAL = 8'h04;

  // decoded effect of one command byte
  typedef struct packed {
    logic              legal;
    logic              chip_rst;
    logic              ld_stat;
    byte_t             stat;
    byte_t             stat_or;
    logic              ld_cause;
    byte_t             cause;
    logic              ld_step;
    logic [SEQ_W-1:0]  step;
    logic              raise;
    logic              sel_go;
    logic              sel_cmdph;
    logic              flush;
    logic              dma;
  } ciu_act_t;
endpackage

// File: rtl/ciu_rst_sync.sv
module ciu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ciu_addr_map.sv
module ciu_addr_map
  import scsi_ciu_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  output ofs_t              ofs,
  output logic              wr_cmd,
  output logic              wr_tgtid,
  output logic              wr_cfg,
  output logic              rd_ack
);
  localparam int TOP = ADDR_SHIFT + OFS_W;

  logic addr_unused_lo, addr_unused_hi;

  assign ofs = addr[ADDR_SHIFT +: OFS_W];

  generate
    if (ADDR_SHIFT > 0) begin : g_lo
      assign addr_unused_lo = ^addr[ADDR_SHIFT-1:0];
    end else begin : g_nolo
      assign addr_unused_lo = 1'b0;
    end
    if (ADDR_W > TOP) begin : g_hi
      assign addr_unused_hi = ^addr[ADDR_W-1:TOP];
    end else begin : g_nohi
      assign addr_unused_hi = 1'b0;
    end
  endgenerate

  assign wr_cmd   = wr_en && (ofs == OFS_CMD);
  assign wr_tgtid = wr_en && (ofs == OFS_TGTID);
  assign wr_cfg   = wr_en && (ofs == OFS_CFG);
  // a write in the same cycle suppresses the acknowledge side effect
  assign rd_ack   = rd_en && !wr_en && (ofs == OFS_CAUSE);
endmodule

// File: rtl/ciu_cmd_decode.sv
module ciu_cmd_decode
  import scsi_ciu_pkg::*;
(
  input  byte_t    cmd,
  input  logic     busrst_masked,
  input  logic     tgt_ok,
  output ciu_act_t act
);
  logic [6:0] op;
  assign op = cmd[6:0];

  always_comb begin
    act = '0;
    act.legal = 1'b1;
    unique case (op)
      OP_NOP, OP_ATN: ;
      OP_FLUSH: begin
        act.ld_cause = 1'b1;
        act.cause    = CS_DONE;
        act.ld_step  = 1'b1;
        act.step     = STEP_ZERO;
        act.flush    = 1'b1;
      end
      OP_CHIPRST: act.chip_rst = 1'b1;
      OP_BUSRST: begin
        act.ld_cause = 1'b1;
        act.cause    = CS_BUSRST;
        act.raise    = !busrst_masked;
      end
      OP_CMPLSEQ: begin
        act.ld_cause = 1'b1;
        act.cause    = CS_DONE;
        act.stat_or  = PH_MSGIN;
        act.raise    = 1'b1;
      end
      OP_MSGOK: begin
        act.ld_cause = 1'b1;
        act.cause    = CS_DISC;
        act.ld_step  = 1'b1;
        act.step     = STEP_ZERO;
        act.raise    = 1'b1;
      end
      OP_SEL, OP_SELSTOP: begin
        if (tgt_ok) begin
          act.sel_go    = 1'b1;
          act.sel_cmdph = (op == OP_SELSTOP);
        end else begin
          act.ld_stat  = 1'b1;
          act.stat     = '0;
          act.ld_cause = 1'b1;
          act.cause    = CS_DISC;
          act.ld_step  = 1'b1;
          act.step     = STEP_ZERO;
          act.raise    = 1'b1;
        end
      end
      OP_SELEN: begin
        act.ld_cause = 1'b1;
        act.cause    = '0;
      end
      default: act.legal = 1'b0;
    endcase
    act.dma = cmd[7] && act.legal && !act.chip_rst;
  end
endmodule

// File: rtl/ciu_state_regs.sv
module ciu_state_regs
  import scsi_ciu_pkg::*;
#(
  parameter int TGT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  byte_t             wdata,
  input  logic              wr_cmd,
  input  logic              wr_tgtid,
  input  logic              wr_cfg,
  input  logic              rd_ack,
  input  ciu_act_t          act,
  input  logic              sel_done,
  output byte_t             stat,
  output byte_t             cause,
  output logic [SEQ_W-1:0]  step,
  output byte_t             cfg,
  output logic              fault,
  output logic [TGT_W-1:0]  tgtid,
  output logic              sel_busy,
  output logic [TGT_W-1:0]  sel_id,
  output logic              flush_pulse,
  output logic              dma_pulse
);
  byte_t             stat_q, stat_n, cause_q, cause_n, cfg_q, cfg_n;
  logic [SEQ_W-1:0]  step_q, step_n;
  logic [TGT_W-1:0]  tgtid_q, tgtid_n, selid_q, selid_n;
  logic              fault_q, fault_n, busy_q, busy_n, cmdph_q, cmdph_n;
  logic              flush_q, flush_n, dma_q, dma_n;

  // next-state: selection completion, then acknowledge read, then writes
  always_comb begin
    stat_n  = stat_q;
    cause_n = cause_q;
    step_n  = step_q;
    cfg_n   = cfg_q;
    tgtid_n = tgtid_q;
    selid_n = selid_q;
    fault_n = fault_q;
    busy_n  = busy_q;
    cmdph_n = cmdph_q;
    flush_n = 1'b0;
    dma_n   = 1'b0;

    if (sel_done && busy_q) begin
      stat_n  = ST_PEND | ST_TCNT | (cmdph_q ? PH_CMD : PH_DOUT);
      cause_n = CS_SVC | CS_DONE;
      step_n  = STEP_DONE;
      busy_n  = 1'b0;
    end

    if (rd_ack) begin
      cause_n = '0;
      stat_n  = stat_n & ~(ST_TCNT | ST_PEND);
      step_n  = STEP_DONE;
    end

    if (wr_tgtid) tgtid_n = wdata[TGT_W-1:0];
    if (wr_cfg)   cfg_n   = wdata;

    if (wr_cmd) begin
      if (!act.legal) begin
        fault_n = 1'b1;
      end else if (act.chip_rst) begin
        stat_n  = '0;
        cause_n = '0;
        step_n  = STEP_ZERO;
        cfg_n   = CFG_INIT;
        tgtid_n = '0;
        selid_n = '0;
        fault_n = 1'b0;
        busy_n  = 1'b0;
        cmdph_n = 1'b0;
      end else begin
        if (act.ld_stat)  stat_n  = act.stat;
        stat_n = stat_n | act.stat_or;
        if (act.ld_cause) cause_n = act.cause;
        if (act.ld_step)  step_n  = act.step;
        if (act.raise)    stat_n  = stat_n | ST_PEND;
        if (act.sel_go) begin
          busy_n  = 1'b1;
          cmdph_n = act.sel_cmdph;
          selid_n = tgtid_q;
        end
        flush_n = act.flush;
        dma_n   = act.dma;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      cause_q <= '0;
      step_q  <= STEP_ZERO;
      cfg_q   <= CFG_INIT;
      tgtid_q <= '0;
      selid_q <= '0;
      fault_q <= 1'b0;
      busy_q  <= 1'b0;
      cmdph_q <= 1'b0;
      flush_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      stat_q  <= stat_n;
      cause_q <= cause_n;
      step_q  <= step_n;
      cfg_q   <= cfg_n;
      tgtid_q <= tgtid_n;
      selid_q <= selid_n;
      fault_q <= fault_n;
      busy_q  <= busy_n;
      cmdph_q <= cmdph_n;
      flush_q <= flush_n;
      dma_q   <= dma_n;
    end
  end

  assign stat        = stat_q;
  assign cause       = cause_q;
  assign step        = step_q;
  assign cfg         = cfg_q;
  assign fault       = fault_q;
  assign tgtid       = tgtid_q;
  assign sel_busy    = busy_q;
  assign sel_id      = selid_q;
  assign flush_pulse = flush_q;
  assign dma_pulse   = dma_q;
endmodule

// File: rtl/scsi_cmd_irq_unit.sv
module scsi_cmd_irq_unit
  import scsi_ciu_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2,
  parameter int TGT_N      = 8,
  localparam int TGT_W     = $clog2(TGT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  input  logic [TGT_N-1:0]  tgt_present,
  output logic              sel_req,
  output logic [TGT_W-1:0]  sel_target,
  input  logic              sel_done,
  output logic              fifo_flush,
  output logic              dma_start
);
  logic             rst_n_int;
  ofs_t             ofs;
  logic             wr_cmd, wr_tgtid, wr_cfg, rd_ack;
  ciu_act_t         act;
  byte_t            stat, cause, cfg;
  logic [SEQ_W-1:0] step;
  logic             fault;
  logic [TGT_W-1:0] tgtid;

  ciu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  ciu_addr_map #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_map (
    .addr(bus_addr), .rd_en(bus_rd), .wr_en(bus_wr), .ofs(ofs),
    .wr_cmd(wr_cmd), .wr_tgtid(wr_tgtid), .wr_cfg(wr_cfg), .rd_ack(rd_ack)
  );

  ciu_cmd_decode u_dec (
    .cmd(bus_wdata),
    .busrst_masked(cfg[CFG_MASKBIT]),
    .tgt_ok(tgt_present[tgtid]),
    .act(act)
  );

  ciu_state_regs #(.TGT_W(TGT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wdata(bus_wdata),
    .wr_cmd(wr_cmd), .wr_tgtid(wr_tgtid), .wr_cfg(wr_cfg), .rd_ack(rd_ack),
    .act(act), .sel_done(sel_done),
    .stat(stat), .cause(cause), .step(step), .cfg(cfg), .fault(fault),
    .tgtid(tgtid), .sel_busy(sel_req), .sel_id(sel_target),
    .flush_pulse(fifo_flush), .dma_pulse(dma_start)
  );

  // read bank
  always_comb begin
    unique case (ofs)
      OFS_STAT:   bus_rdata = stat;
      OFS_CAUSE:  bus_rdata = cause;
      OFS_STEP:   bus_rdata = {{(BYTE_W-SEQ_W){1'b0}}, step};
      OFS_CFG:    bus_rdata = cfg;
      OFS_FAULT:  bus_rdata = {7'b0, fault};
      OFS_CHIPID: bus_rdata = CHIPID_VAL;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = stat[7];
endmodule

// File: rtl/ciu_checker.sv
module ciu_checker #(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              sel_done,
  input logic              sel_req,
  input logic              irq,
  input logic              fifo_flush,
  input logic              dma_start
);
  logic [3:0] c_ofs;
  logic       c_cmd_wr, c_ack_rd;
  assign c_ofs    = 4'(bus_addr >> ADDR_SHIFT);
  assign c_cmd_wr = bus_wr && (c_ofs == 4'h3);
  assign c_ack_rd = bus_rd && !bus_wr && (c_ofs == 4'h5);

  // R5
  ack_lowers_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ack_rd && !sel_done) |=> !irq);

  // R4
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(c_cmd_wr) || $past(sel_done && sel_req)));

  // R6
  flush_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> $past(c_cmd_wr && bus_wdata[6:0] == 7'h01));

  // R13
  dma_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(c_cmd_wr && bus_wdata[7]));

  // R8
  sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_req) |-> ($past(sel_done) || $past(c_cmd_wr && bus_wdata[6:0] == 7'h02)));

  // R11
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && !sel_done && !c_cmd_wr) |=> sel_req);
endmodule

bind scsi_cmd_irq_unit ciu_checker #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .sel_done(sel_done), .sel_req(sel_req), .irq(irq),
  .fifo_flush(fifo_flush), .dma_start(dma_start)
);

// File: tb/tb_scsi_cmd_irq_unit.sv
module tb_scsi_cmd_irq_unit;
  localparam int CLK_NS = 8;
  localparam int AW = 8;
  localparam int SH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, sel_req, sel_done = 1'b0, fifo_flush, dma_start;
  logic [7:0] tgt_present = '0;
  logic [2:0] sel_target;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  scsi_cmd_irq_unit #(.ADDR_W(AW), .ADDR_SHIFT(SH), .TGT_N(8)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tgt_present(tgt_present),
    .sel_req(sel_req), .sel_target(sel_target), .sel_done(sel_done),
    .fifo_flush(fifo_flush), .dma_start(dma_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference model, updated at each rising edge
  int m_stat, m_cause, m_step, m_cfg, m_tid, m_fault, m_busy, m_stop, m_sid, m_flush, m_dma;

  task automatic model_init();
    m_stat = 0; m_cause = 0; m_step = 0; m_cfg = 7; m_tid = 0; m_fault = 0;
    m_busy = 0; m_stop = 0; m_sid = 0; m_flush = 0; m_dma = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_init();
    else begin
      int o, code;
      bit ok;
      o = (int'(bus_addr) >> SH) & 15;
      m_flush = 0; m_dma = 0;
      if (sel_done && m_busy == 1) begin
        m_stat = 'h90 + (m_stop ? 2 : 0); m_cause = 'h18; m_step = 4; m_busy = 0;
      end
      if (bus_rd && !bus_wr && o == 5) begin
        m_cause = 0; m_stat = m_stat & 'h6F; m_step = 4;
      end
      if (bus_wr && o == 4) m_tid = int'(bus_wdata) & 7;
      if (bus_wr && o == 8) m_cfg = int'(bus_wdata);
      if (bus_wr && o == 3) begin
        code = int'(bus_wdata) & 'h7F;
        ok = 1;
        case (code)
          'h00, 'h1A: ;
          'h01: begin m_cause = 8; m_step = 0; m_flush = 1; end
          'h02: model_init();
          'h03: begin m_cause = 'h80; if (((m_cfg >> 6) & 1) == 0) m_stat |= 'h80; end
          'h11: begin m_cause = 8; m_stat |= 'h87; end
          'h12: begin m_cause = 'h20; m_step = 0; m_stat |= 'h80; end
          'h42, 'h43: begin
            if (tgt_present[m_tid]) begin m_busy = 1; m_stop = (code == 'h43); m_sid = m_tid; end
            else begin m_stat = 'h80; m_cause = 'h20; m_step = 0; end
          end
          'h44: m_cause = 0;
          default: begin ok = 0; m_fault = 1; end
        endcase
        if (ok && bus_wdata[7] && code != 2) m_dma = 1;
      end
    end
  end

  // compare the outputs with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 irq vs model", irq, m_stat[7]);
      chk("R11 sel_req vs model", sel_req, m_busy[0]);
      chk("R11 sel_target vs model", sel_target, m_sid[2:0]);
      chk("R6 fifo_flush vs model", fifo_flush, m_flush[0]);
      chk("R13 dma_start vs model", dma_start, m_dma[0]);
    end
  end

  task automatic wr(input int ofs, input int val);
    @(negedge clk);
    bus_addr = AW'(ofs << SH); bus_wdata = 8'(val); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_raw(input int addr, input string req, input int exp);
    @(negedge clk);
    bus_addr = AW'(addr); bus_rd = 1'b1;
    #1;
    chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd(input int ofs, input string req, input int exp);
    rd_raw(ofs << SH, req, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); sel_done = 1'b1;
    @(negedge clk); sel_done = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(4, "R1 status", 8'h00);
    rd(6, "R1 step", 0);
    rd(8, "R1 cfg", 8'h07);
    rd('hE, "R1 chip id", 8'h04);
    rd('hB, "R1 fault", 0);
    rd(5, "R1 cause", 8'h00);

    // R2 low address bits ignored
    rd_raw((8 << SH) | 3, "R2 cfg alias", 8'h07);
    rd_raw((6 << SH) | 1, "R2 step alias", 4);

    // R3 separate banks
    wr(4, 8'h05);
    rd(4, "R3 status untouched", 8'h00);

    // R10 absent target
    tgt_present = 8'h02;
    wr(3, 8'h42);
    chk("R10 irq", irq, 1);
    rd(4, "R10 status", 8'h80);
    rd(6, "R10 step", 0);
    rd(5, "R10 cause", 8'h20);
    chk("R5 irq lowered", irq, 0);
    rd(4, "R5 status cleared", 8'h00);
    rd(6, "R5 step", 4);
    rd(5, "R5 cause cleared", 8'h00);

    // R11 present target, stop variant
    wr(4, 8'h01);
    wr(3, 8'h43);
    chk("R11 sel_req", sel_req, 1);
    chk("R11 sel_target", sel_target, 1);
    repeat (3) @(negedge clk);
    chk("R11 still waiting", sel_req, 1);
    pulse_done();
    chk("R11 sel_req dropped", sel_req, 0);
    chk("R11 irq", irq, 1);
    rd(4, "R11 status stop", 8'h92);
    rd(6, "R11 step", 4);
    rd(5, "R11 cause", 8'h18);
    rd(4, "R5 tc and pend cleared", 8'h02);
    // R11 without stop
    wr(3, 8'h42);
    pulse_done();
    rd(4, "R11 status atn", 8'h90);
    rd(5, "R11 cause atn", 8'h18);

    // R6 flush
    wr(3, 8'h01);
    chk("R6 flush pulse", fifo_flush, 1);
    chk("R6 no irq", irq, 0);
    @(negedge clk);
    chk("R6 flush one cycle", fifo_flush, 0);
    rd(6, "R6 step", 0);
    rd(5, "R6 cause", 8'h08);

    // R7 bus reset, unmasked then masked
    wr(3, 8'h03);
    chk("R7 irq unmasked", irq, 1);
    rd(5, "R7 cause", 8'h80);
    wr(8, 8'h47);
    rd(8, "R7 cfg written", 8'h47);
    wr(3, 8'h03);
    chk("R7 irq masked", irq, 0);
    rd(5, "R7 cause masked", 8'h80);

    // R9 misc commands
    wr(3, 8'h12);
    chk("R9 msgok irq", irq, 1);
    rd(6, "R9 msgok step", 0);
    rd(5, "R9 msgok cause", 8'h20);
    wr(3, 8'h01);
    wr(3, 8'h44);
    rd(5, "R9 selen cause", 8'h00);
    wr(3, 8'h11);
    chk("R9 cmplseq irq", irq, 1);
    rd(4, "R9 cmplseq status", 8'h87);
    rd(5, "R9 cmplseq cause", 8'h08);
    wr(3, 8'h1A);
    rd(4, "R9 atn status", 8'h07);
    rd(6, "R9 atn step", 4);
    chk("R9 atn irq", irq, 0);

    // R12 illegal code
    wr(3, 8'h55);
    rd(4, "R12 status kept", 8'h07);
    rd(6, "R12 step kept", 4);
    rd('hB, "R12 fault set", 1);
    wr(3, 8'h44);
    rd('hB, "R12 fault sticky", 1);

    // R13 DMA bit
    wr(3, 8'h81);
    chk("R13 dma pulse", dma_start, 1);
    chk("R13 code decoded", fifo_flush, 1);
    wr(3, 8'hD5);
    chk("R13 no dma on illegal", dma_start, 0);

    // R8 chip reset cancels selection
    wr(3, 8'h43);
    chk("R8 selection pending", sel_req, 1);
    wr(3, 8'h02);
    chk("R8 sel_req cleared", sel_req, 0);
    chk("R8 irq", irq, 0);
    rd(8, "R8 cfg", 8'h07);
    rd('hB, "R8 fault", 0);
    rd(4, "R8 status", 8'h00);
    rd(6, "R8 step", 0);
    rd('hE, "R8 chip id", 8'h04);
    pulse_done();
    rd(4, "R8 stale done ignored", 8'h00);
    rd(5, "R8 cause", 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule